// File: doc/BRIEF.md
# Multi-Source Glitch-Free Clock Selector

This block picks one of N clock inputs and passes it to a single output clock without ever producing a shortened high or low phase. A binary index names the wanted source. Each source owns a lane that runs entirely in that source's clock domain. A lane first registers its request on the rising edge of its own clock. It then registers the result into an enable on the falling edge of the same clock. A lane may only arm while every other lane's enable is low, so a handover always stops the old clock before the new one starts. The sources may be completely unrelated in frequency and phase.

Each lane is a two-state machine held in the falling-edge register:
- `LANE_OFF` moves to `LANE_ON` (transition "arm seen") when the rising-edge stage holds a request with all other enables clear.
- `LANE_ON` moves back to `LANE_OFF` (transition "arm lost") when that stage drops, either because the request went away or because the lane was reset.

The output clock is the OR of every source ANDed with its own enable. An index of N or above requests no source, and the output then stays low. The enable vector is brought out as status.

The user changes the index only after the status vector has settled on the previous choice.

Top module: `gcs_clock_select`

## Requirements
- R1: While rst_n is low, every en_stat bit is 0 and clk_out is 0, whatever sel_idx holds; an asynchronous reset clears an active enable at once.
- R2: With sel_idx = k and k < N, en_stat settles to the one-hot value with only bit k set, and clk_out then equals clk_src[k].
- R3: At no instant is more than one bit of en_stat high.
- R4: An enable bit rises only when all other enable bits are already low, strictly after the last one fell. It rises only if sel_idx named that source at the preceding rising edge of that source's clock.
- R5: A sel_idx value of N or above drives every en_stat bit to 0 and holds clk_out low.
- R6: Outside reset, en_stat bit k changes only at a falling edge of clk_src[k], so only while that clock is low.
- R7: Every high phase and every low phase of clk_out lasts at least the shortest half-period among the running sources.
- R8: A source that is not toggling and not selected never blocks the others. After reset with a stopped source, selecting it leaves en_stat at 0 and clk_out low. Selecting a running source afterwards still enables that source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | N | Candidate source clocks, bit k is source k |
| rst_n | input | 1 | Asynchronous active-low reset for all lanes |
| sel_idx | input | SEL_W | Binary index of the wanted source; N or above selects none |
| clk_out | output | 1 | Selected clock, AND-OR of sources and enables |
| en_stat | output | N | Per-source enable, one-hot or zero |

## Verification
The hardest situation to reach from the ports is a source that is stalled while the others run. That source's lane can never change state, so a design that reset the lane high, or one that waited on the stalled lane's feedback, would lock the selector. The bench stops one source clock during reset, selects it, then moves to a live source and later revives the stalled one. Random index changes, including out-of-range values, run across four unrelated clock periods. Monitors time every output phase and every enable edge against its own source clock.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;

    // Lane state held in the falling-edge enable register.
    typedef enum logic {
        LANE_OFF = 1'b0,
        LANE_ON  = 1'b1
    } lane_state_t;

endpackage

// File: rtl/gcs_sel_decode.sv
`timescale 1ns/1ps
module gcs_sel_decode #(
    parameter int N     = 4,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel_idx,
    output logic [N-1:0]     req_oh
);

    // Out-of-range indices match no lane, leaving the request vector zero.
    always_comb begin
        req_oh = '0;
        for (int k = 0; k < N; k++) begin
            req_oh[k] = (sel_idx == SEL_W'(k));
        end
    end

endmodule

// File: rtl/gcs_lane.sv
`timescale 1ns/1ps
module gcs_lane
    import gcs_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDX = 0
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic [N-1:0] en_all,
    output logic         en_o
);

    localparam logic [N-1:0] SELF = N'(1) << IDX;

    logic        others_clear;
    logic        arm_q;
    lane_state_t st_q;
    lane_state_t st_d;

    // Feedback from every other lane: all must be deselected.
    assign others_clear = ((en_all & ~SELF) == '0);

    // First stage: rising edge of this lane's own clock.
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else begin
            arm_q <= req_i & others_clear;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LANE_OFF: if (arm_q)  st_d = LANE_ON;
            LANE_ON:  if (!arm_q) st_d = LANE_OFF;
            default:  st_d = LANE_OFF;
        endcase
    end

    // Second stage: falling edge, so the enable only moves while the clock is low.
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LANE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Output decode.
    always_comb begin
        en_o = (st_q == LANE_ON);
    end

endmodule

// File: rtl/gcs_out_merge.sv
`timescale 1ns/1ps
module gcs_out_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] clk_src,
    input  logic [N-1:0] en,
    output logic         clk_out
);

    logic [N-1:0] gated;

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = clk_src[g] & en[g];
    end

    assign clk_out = |gated;

endmodule

// File: rtl/gcs_clock_select.sv
`timescale 1ns/1ps
module gcs_clock_select #(
    parameter int N     = 4,
    parameter int SEL_W = $clog2(N) + 1
) (
    input  logic [N-1:0]     clk_src,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_idx,
    output logic             clk_out,
    output logic [N-1:0]     en_stat
);

    logic [N-1:0] req_oh;

    gcs_sel_decode #(
        .N     (N),
        .SEL_W (SEL_W)
    ) u_decode (
        .sel_idx (sel_idx),
        .req_oh  (req_oh)
    );

    for (genvar g = 0; g < N; g++) begin : g_lane
        gcs_lane #(
            .N   (N),
            .IDX (g)
        ) u_lane (
            .clk_i  (clk_src[g]),
            .rst_n  (rst_n),
            .req_i  (req_oh[g]),
            .en_all (en_stat),
            .en_o   (en_stat[g])
        );
    end

    gcs_out_merge #(
        .N (N)
    ) u_merge (
        .clk_src (clk_src),
        .en      (en_stat),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/gcs_clock_select_chk.sv
`timescale 1ns/1ps
module gcs_clock_select_chk #(
    parameter int N     = 4,
    parameter int SEL_W = 3
) (
    input logic [N-1:0]     clk_src,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel_idx,
    input logic             clk_out,
    input logic [N-1:0]     en_stat
);

    // R3: never two owners of the output.
    always_comb begin
        if (rst_n === 1'b1 && !$isunknown(en_stat)) begin
            p_excl_r3: assert ($countones(en_stat) <= 1)
                else $error("two enables high: %b", en_stat);
        end
    end

    // R7: each output rising edge belongs to exactly one enabled source.
    p_owner_r7: assert property (@(posedge clk_out) disable iff (!rst_n)
        $countones(en_stat) == 1);

    for (genvar g = 0; g < N; g++) begin : g_lane_chk
        localparam logic [N-1:0] SELF = N'(1) << g;

        // R4: make only after every other lane broke.
        p_clear_r4: assert property (@(posedge clk_src[g]) disable iff (!rst_n)
            $rose(en_stat[g]) |-> ((en_stat & ~SELF) == '0));

        // R4: a lane rises only when the index named it one edge earlier.
        p_req_r4: assert property (@(posedge clk_src[g]) disable iff (!rst_n)
            $rose(en_stat[g]) |-> ($past(sel_idx) == SEL_W'(g)));

        // R6: enable moves only while its own clock is low.
        always @(en_stat[g]) begin
            if (rst_n === 1'b1) begin
                p_fall_r6: assert (clk_src[g] == 1'b0)
                    else $error("enable %0d moved while its clock was high", g);
            end
        end
    end

endmodule

bind gcs_clock_select gcs_clock_select_chk #(
    .N     (N),
    .SEL_W (SEL_W)
) u_chk (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .sel_idx (sel_idx),
    .clk_out (clk_out),
    .en_stat (en_stat)
);

// File: tb/test_gcs_clock_select.sv
`timescale 1ns/1ps
module test_gcs_clock_select;

    localparam int  N        = 4;
    localparam int  SEL_W    = 3;
    localparam int  HALF [N] = '{10, 13, 19, 7};
    localparam real MIN_HALF = 7.0;

    logic             bench_clk = 1'b0;
    logic [N-1:0]     clk_src;
    logic [N-1:0]     run;
    logic             rst_n;
    logic [SEL_W-1:0] sel_idx;
    wire              clk_out;
    wire  [N-1:0]     en_stat;

    int n_chk = 0;
    int n_fail = 0;
    int glitch_bad = 0;
    int excl_bad = 0;
    int bmb_bad = 0;
    int edge_bad = 0;

    always #10 bench_clk = ~bench_clk;   // 50 MHz

    for (genvar g = 0; g < N; g++) begin : g_src
        logic c;
        initial begin
            c = 1'b0;
            #(g * 3 + 1);
            forever begin
                #(HALF[g]);
                c = run[g] ? ~c : 1'b0;
            end
        end
        assign clk_src[g] = c;
    end

    gcs_clock_select #(
        .N     (N),
        .SEL_W (SEL_W)
    ) i_gcs_clock_select (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .sel_idx (sel_idx),
        .clk_out (clk_out),
        .en_stat (en_stat)
    );

    // R7 monitor: width of every output phase.
    realtime t_last_out = 0;
    always @(clk_out) begin
        if (rst_n === 1'b1 && !$isunknown(clk_out) && t_last_out > 0) begin
            if ($realtime - t_last_out < MIN_HALF - 0.01) glitch_bad++;
        end
        t_last_out = $realtime;
    end

    // R3, R4, R6 monitor on enable changes.
    logic [N-1:0] en_prev = '0;
    realtime      t_last_fall = -1.0;
    always @(en_stat) begin
        if (!$isunknown(en_stat) && rst_n === 1'b1) begin
            if ($countones(en_stat) > 1) excl_bad++;
            for (int b = 0; b < N; b++) begin
                if (en_stat[b] != en_prev[b] && clk_src[b] !== 1'b0) edge_bad++;
            end
            for (int b = 0; b < N; b++) begin
                if (en_prev[b] && !en_stat[b]) t_last_fall = $realtime;
            end
            for (int b = 0; b < N; b++) begin
                if (!en_prev[b] && en_stat[b]) begin
                    if (!(t_last_fall < $realtime)) bmb_bad++;
                end
            end
        end
        en_prev = en_stat;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_en(input int k);
        return (k < N) ? (N'(1) << k) : '0;
    endfunction

    task automatic follow(input int k, input string rq);
        int bad = 0;
        repeat (12) begin
            #5;
            if (clk_out !== ((k < N) ? clk_src[k] : 1'b0)) bad++;
        end
        chk(rq, 32'(bad), 32'd0);
    endtask

    task automatic pick(input int k);
        @(posedge bench_clk);
        #0.5;
        sel_idx = SEL_W'(k);
        for (int s = 0; s < 80 && en_stat !== exp_en(k); s++) #10;
        chk((k < N) ? "R2 enable" : "R5 enable", 32'(en_stat), 32'(exp_en(k)));
        follow(k, (k < N) ? "R2 follow" : "R5 output low");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'd2024));
        run     = '1;
        rst_n   = 1'b0;
        sel_idx = SEL_W'(2);

        // R1: quiet during reset.
        repeat (5) @(posedge bench_clk);
        #0.5;
        bad = 0;
        repeat (10) begin
            #3;
            if (en_stat !== '0 || clk_out !== 1'b0) bad++;
        end
        chk("R1 reset quiet", 32'(bad), 32'd0);
        rst_n = 1'b1;

        // Directed walk, including out-of-range indices (R5).
        pick(2);
        pick(1);
        pick(3);
        pick(0);
        pick(3);
        pick(5);
        pick(0);
        pick(7);
        pick(4);
        pick(1);

        // Random index changes.
        for (int it = 0; it < 40; it++) begin
            int k = $urandom_range(0, (1 << SEL_W) - 1);
            pick(k);
        end

        // R1: reset while a lane is active clears it at once.
        pick(2);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear enable", 32'(en_stat), 32'd0);
        chk("R1 async clear output", 32'(clk_out), 32'd0);

        // R8: a stalled source during reset.
        run[3]  = 1'b0;
        sel_idx = SEL_W'(3);
        #100;
        rst_n = 1'b1;
        #300.5;
        chk("R8 stalled selected enable", 32'(en_stat), 32'd0);
        follow(N, "R8 stalled output low");
        pick(1);
        chk("R8 live source after stall", 32'(en_stat), 32'b0010);
        run[3] = 1'b1;
        pick(3);
        chk("R8 revived source", 32'(en_stat), 32'b1000);
        pick(0);

        chk("R7 pulse widths", 32'(glitch_bad), 32'd0);
        chk("R3 exclusive enables", 32'(excl_bad), 32'd0);
        chk("R4 break before make", 32'(bmb_bad), 32'd0);
        chk("R6 falling edge only", 32'(edge_bad), 32'd0);

        summary();
        $finish;
    end

endmodule